// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer

This block governs a low-power sleep state for a synchronous memory. Sleep is requested through an asynchronous, active-high input. The block brings that request into the clock domain through a flop synchroniser. It then times a fixed entry interval before it reports the part as asleep. When the request is withdrawn, it times a fixed exit interval and then a recovery interval before accesses are allowed again. While any of these intervals is running, and while the part is asleep, an access-block output is held high. The surrounding logic uses it to refuse new accesses and to keep the data outputs in high impedance. The memory contents are assumed to be retained by the array. Power switching is done elsewhere.

The sequencer also checks the protocol around sleep. If a request arrives while the chip is selected, it raises a violation pulse. If an access is still pending at that moment, it raises an abort pulse, because that access is treated as not completed. During the recovery interval every chip enable and both address strobes must stay inactive. Any activity there raises a second violation pulse.

The controller has five states:
- AWAKE: normal operation.
- ENTER: the entry interval is being timed.
- ASLEEP: the part is in sleep.
- EXIT: the exit interval is being timed.
- RECOVER: the recovery interval is being timed.

The transitions are:
- start-entry (AWAKE→ENTER): the synchronised request is seen.
- entry-done (ENTER→ASLEEP): the entry count expires.
- begin-exit (ASLEEP→EXIT): the synchronised request drops.
- exit-done (EXIT→RECOVER): the exit count expires.
- recovered (RECOVER→AWAKE): the recovery count expires.
- re-entry (EXIT or RECOVER→ENTER): the request returns before the part is awake.

Top module: `sleep_sequencer`

## Requirements
- R1: After reset the controller is in AWAKE and `asleep`, `acc_block`, `viol_sel`, `viol_recov` and `acc_abort` are all 0.
- R2: Suppose `sleep_req_a` rises before clock edge 1 while the controller is AWAKE. Then `acc_block` goes to 1 after edge SYNC_STAGES+1 (edge 3 by default). `asleep` goes to 1 after edge SYNC_STAGES+1+ENTRY_CYC (edge 5 by default).
- R3: Suppose `sleep_req_a` falls before clock edge 1 while the controller is ASLEEP. Then `asleep` returns to 0 after edge SYNC_STAGES+1.
- R4: After `asleep` falls, `acc_block` stays at 1 for EXIT_CYC+RECOV_CYC further edges and then returns to 0.
- R5: `acc_block` is 1 in ENTER, ASLEEP, EXIT and RECOVER and 0 only in AWAKE. It is therefore always 1 while `asleep` is 1.
- R6: `viol_sel` is a one-cycle pulse on the same edge that raises `acc_block` from AWAKE. It fires if and only if the chip was selected in the cycle before that edge. Selected means `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0 together.
- R7: `acc_abort` is a one-cycle pulse on the same edge that raises `acc_block` from AWAKE. It fires if and only if `acc_pend` was 1 in the cycle before that edge.
- R8: `viol_recov` pulses one edge after any cycle spent in RECOVER in which at least one of these inputs is active: `ce_a_n`=0, `ce_b`=1, `ce_c_n`=0, `strb_p_n`=0, `strb_c_n`=0. The same inputs in AWAKE or EXIT cycles never raise it.
- R9: A request that returns during EXIT or RECOVER takes the controller back to ENTER without `acc_block` ever falling.
- R10: A request that drops during ENTER does not shorten the entry. `asleep` still rises on schedule, and exit then begins on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_a | input | 1 | Asynchronous sleep request, active high |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| strb_p_n | input | 1 | Processor-side address strobe, active low |
| strb_c_n | input | 1 | Controller-side address strobe, active low |
| acc_pend | input | 1 | An access is in flight |
| asleep | output | 1 | Part is in the sleep state |
| acc_block | output | 1 | Refuse new accesses and hold the data outputs off |
| viol_sel | output | 1 | Pulse: sleep requested while selected |
| viol_recov | output | 1 | Pulse: enable or strobe active during recovery |
| acc_abort | output | 1 | Pulse: pending access dropped at sleep entry |

## Verification
The assertions assume that the request pulses last long enough for the synchroniser to see each edge. They also assume that no reset arrives partway through a sequence. Under those conditions the pulses line up with the rising edge of `acc_block`, and the blocking output covers every cycle spent asleep. The stimulus changes the request only at falling clock edges. It holds each level for the full scheduled interval, or deliberately flips it inside ENTER, EXIT or RECOVER to cover R9 and R10. Enable and strobe patterns are swept exhaustively: all eight enable combinations at entry, and all 32 enable and strobe combinations in the first recovery cycle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE   = 3'd0,
        ST_ENTER   = 3'd1,
        ST_ASLEEP  = 3'd2,
        ST_EXIT    = 3'd3,
        ST_RECOVER = 3'd4
    } slp_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/sleep_req_sync.sv
module sleep_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_a,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_a;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_a};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sleep_dwell_cnt.sv
module sleep_dwell_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_seq_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2,
    parameter int W         = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_s,
    input  logic         expired,
    output logic         load,
    output logic [W-1:0] load_val,
    output logic         asleep,
    output logic         acc_block,
    output logic         entry_start,
    output logic         in_recover
);
    localparam logic [W-1:0] ENTRY_LD = W'(ENTRY_CYC - 1);
    localparam logic [W-1:0] EXIT_LD  = W'(EXIT_CYC - 1);
    localparam logic [W-1:0] RECOV_LD = W'(RECOV_CYC - 1);

    slp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_AWAKE: begin
                if (req_s) begin
                    state_d  = ST_ENTER;
                    load     = 1'b1;
                    load_val = ENTRY_LD;
                end
            end
            ST_ENTER: begin
                if (expired) state_d = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    state_d  = ST_EXIT;
                    load     = 1'b1;
                    load_val = EXIT_LD;
                end
            end
            ST_EXIT: begin
                if (req_s) begin
                    state_d  = ST_ENTER;
                    load     = 1'b1;
                    load_val = ENTRY_LD;
                end else if (expired) begin
                    state_d  = ST_RECOVER;
                    load     = 1'b1;
                    load_val = RECOV_LD;
                end
            end
            ST_RECOVER: begin
                if (req_s) begin
                    state_d  = ST_ENTER;
                    load     = 1'b1;
                    load_val = ENTRY_LD;
                end else if (expired) begin
                    state_d = ST_AWAKE;
                end
            end
            default: state_d = ST_AWAKE;
        endcase
    end

    always_comb begin
        asleep      = (state_q == ST_ASLEEP);
        acc_block   = (state_q != ST_AWAKE);
        entry_start = (state_q == ST_AWAKE) && req_s;
        in_recover  = (state_q == ST_RECOVER);
    end
endmodule

// File: rtl/sleep_rule_mon.sv
module sleep_rule_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic entry_start,
    input  logic in_recover,
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    input  logic strb_p_n,
    input  logic strb_c_n,
    input  logic acc_pend,
    output logic viol_sel,
    output logic viol_recov,
    output logic acc_abort
);
    logic selected;
    logic any_active;

    always_comb begin
        selected   = !ce_a_n && ce_b && !ce_c_n;
        any_active = !ce_a_n || ce_b || !ce_c_n || !strb_p_n || !strb_c_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_sel   <= 1'b0;
            viol_recov <= 1'b0;
            acc_abort  <= 1'b0;
        end else begin
            viol_sel   <= entry_start && selected;
            viol_recov <= in_recover && any_active;
            acc_abort  <= entry_start && acc_pend;
        end
    end
endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
    import sleep_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_a,
    input  logic ce_a_n,
    input  logic ce_b,
    input  logic ce_c_n,
    input  logic strb_p_n,
    input  logic strb_c_n,
    input  logic acc_pend,
    output logic asleep,
    output logic acc_block,
    output logic viol_sel,
    output logic viol_recov,
    output logic acc_abort
);
    localparam int MAX_CYC = max3(ENTRY_CYC, EXIT_CYC, RECOV_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             req_s;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             entry_start;
    logic             in_recover;

    sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (sleep_req_a),
        .q     (req_s)
    );

    sleep_dwell_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sleep_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .RECOV_CYC (RECOV_CYC),
        .W         (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_s       (req_s),
        .expired     (expired),
        .load        (load),
        .load_val    (load_val),
        .asleep      (asleep),
        .acc_block   (acc_block),
        .entry_start (entry_start),
        .in_recover  (in_recover)
    );

    sleep_rule_mon u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_start (entry_start),
        .in_recover  (in_recover),
        .ce_a_n      (ce_a_n),
        .ce_b        (ce_b),
        .ce_c_n      (ce_c_n),
        .strb_p_n    (strb_p_n),
        .strb_c_n    (strb_c_n),
        .acc_pend    (acc_pend),
        .viol_sel    (viol_sel),
        .viol_recov  (viol_recov),
        .acc_abort   (acc_abort)
    );
endmodule

// File: rtl/sleep_sequencer_chk.sv
module sleep_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic asleep,
    input logic acc_block,
    input logic viol_sel,
    input logic viol_recov,
    input logic acc_abort
);
    a_r5_asleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> acc_block);

    a_r2_entry_was_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(acc_block));

    a_r4_release_not_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_block) |-> !$past(asleep));

    a_r6_sel_single: assert property (@(posedge clk) disable iff (!rst_n)
        viol_sel |=> !viol_sel);

    a_r6_sel_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        viol_sel |-> $rose(acc_block));

    a_r7_abort_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        acc_abort |-> $rose(acc_block));

    a_r8_recov_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        viol_recov |-> $past(acc_block) && !$past(asleep));
endmodule

bind sleep_sequencer sleep_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .asleep     (asleep),
    .acc_block  (acc_block),
    .viol_sel   (viol_sel),
    .viol_recov (viol_recov),
    .acc_abort  (acc_abort)
);

// File: tb/test_sleep_sequencer.sv
module test_sleep_sequencer;
    localparam int SYNC  = 2;
    localparam int ENTRY = 2;
    localparam int EXITC = 2;
    localparam int RECOV = 2;
    localparam int ON_EDGE    = SYNC + 1;
    localparam int SLEEP_EDGE = SYNC + 1 + ENTRY;
    localparam int REC_START  = SYNC + 1 + EXITC;
    localparam int AWAKE_EDGE = SYNC + 1 + EXITC + RECOV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req_a = 1'b0;
    logic ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic strb_p_n = 1'b1, strb_c_n = 1'b1;
    logic acc_pend = 1'b0;
    logic asleep, acc_block, viol_sel, viol_recov, acc_abort;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sleep_sequencer #(
        .SYNC_STAGES(SYNC), .ENTRY_CYC(ENTRY), .EXIT_CYC(EXITC), .RECOV_CYC(RECOV)
    ) i_sleep_sequencer (
        .clk(clk), .rst_n(rst_n), .sleep_req_a(sleep_req_a),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .acc_pend(acc_pend),
        .asleep(asleep), .acc_block(acc_block), .viol_sel(viol_sel),
        .viol_recov(viol_recov), .acc_abort(acc_abort)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // edge: advance one rising edge, return at the following falling edge
    task automatic edge1();
        @(posedge clk);
        @(negedge clk);
    endtask

    // act bits: 0 ce_a_n low, 1 ce_b high, 2 ce_c_n low, 3 strb_p_n low, 4 strb_c_n low
    task automatic drive_act(input logic [4:0] act);
        ce_a_n   = !act[0];
        ce_b     = act[1];
        ce_c_n   = !act[2];
        strb_p_n = !act[3];
        strb_c_n = !act[4];
    endtask

    // enter sleep with enable pattern en[2:0] and pending flag
    task automatic go_sleep(input logic [2:0] en, input logic pend);
        drive_act({2'b00, en});
        acc_pend    = pend;
        sleep_req_a = 1'b1;
        for (int k = 1; k <= SLEEP_EDGE + 1; k++) begin
            edge1();
            if (k == ON_EDGE) begin
                drive_act(5'b0);
                acc_pend = 1'b0;
            end
            check("R2 acc_block", acc_block, (k >= ON_EDGE) ? 1 : 0);
            check("R2 asleep", asleep, (k >= SLEEP_EDGE) ? 1 : 0);
            check("R6 viol_sel", viol_sel, (k == ON_EDGE && en == 3'b111) ? 1 : 0);
            check("R7 acc_abort", acc_abort, (k == ON_EDGE && pend) ? 1 : 0);
        end
    endtask

    // wake with activity pattern driven for one cycle ending at edge t
    task automatic go_wake(input logic [4:0] act, input int t);
        bit inwin;
        inwin = (t > REC_START) && (t <= AWAKE_EDGE);
        sleep_req_a = 1'b0;
        if (t == 1) drive_act(act);
        for (int k = 1; k <= AWAKE_EDGE + 2; k++) begin
            edge1();
            if (k + 1 == t) drive_act(act);
            else            drive_act(5'b0);
            check("R3 asleep", asleep, (k < ON_EDGE) ? 1 : 0);
            check("R4 acc_block", acc_block, (k < AWAKE_EDGE) ? 1 : 0);
            check("R8 viol_recov", viol_recov, (k == t && inwin && act != 5'b0) ? 1 : 0);
        end
    endtask

    initial begin
        drive_act(5'b0);
        repeat (3) @(negedge clk);
        check("R1 asleep", asleep, 0);
        check("R1 acc_block", acc_block, 0);
        check("R1 pulses", {viol_sel, viol_recov, acc_abort}, 0);
        rst_n = 1'b1;
        edge1();
        edge1();
        check("R1 idle", {asleep, acc_block}, 0);

        // R6 sweep of entry enable patterns, R7 with pending both ways
        for (int en = 0; en < 8; en++) begin
            go_sleep(en[2:0], en[0]);
            go_wake(5'b0, 1);
        end

        // R8 sweep of all activity patterns in first recovery cycle
        for (int a = 0; a < 32; a++) begin
            go_sleep(3'b000, 1'b0);
            go_wake(a[4:0], REC_START + 1);
        end
        // R8 window edges: EXIT, last RECOVER, AWAKE
        go_sleep(3'b000, 1'b0);
        go_wake(5'b11111, REC_START);
        go_sleep(3'b000, 1'b0);
        go_wake(5'b01000, AWAKE_EDGE);
        go_sleep(3'b000, 1'b0);
        go_wake(5'b10000, AWAKE_EDGE + 1);

        // R9 re-entry from EXIT: raise request right after asleep falls
        go_sleep(3'b000, 1'b0);
        sleep_req_a = 1'b0;
        for (int k = 1; k <= ON_EDGE; k++) edge1();
        check("R9 asleep fell", asleep, 0);
        sleep_req_a = 1'b1;
        for (int k = 1; k <= SLEEP_EDGE + 1; k++) begin
            edge1();
            check("R9 acc_block held", acc_block, 1);
            check("R9 asleep", asleep, (k >= SLEEP_EDGE) ? 1 : 0);
            check("R9 no viol_sel", viol_sel, 0);
        end
        go_wake(5'b0, 1);

        // R10 drop during ENTER
        sleep_req_a = 1'b1;
        for (int k = 1; k <= ON_EDGE; k++) edge1();
        check("R10 acc_block", acc_block, 1);
        sleep_req_a = 1'b0;
        begin
            int fall;
            fall = (ON_EDGE + SYNC + 1 > SLEEP_EDGE) ? ON_EDGE + SYNC + 1 : SLEEP_EDGE + 1;
            for (int k = ON_EDGE + 1; k <= fall + EXITC + RECOV + 1; k++) begin
                edge1();
                check("R10 asleep", asleep, (k >= SLEEP_EDGE && k < fall) ? 1 : 0);
                check("R10 acc_block", acc_block, (k < fall + EXITC + RECOV) ? 1 : 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule